// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a byte-wide SPI master that a processor drives through a small 32-bit register bus. Software fills a transmit queue through one data port, and the block starts shifting on its own as long as the queue holds bytes, the controller is switched on, master mode is selected and the manual-start bit is clear. Every byte shifted out brings one byte back in. That byte lands in a receive queue, and software drains it through a second data port. Both queues hold 128 bytes by default.

The shift engine is a three-state machine. ST_IDLE holds SCLK at its rest level. ST_LEAD is the first half of a bit time, and at its end MISO is sampled. ST_TRAIL is the second half, and at its end MOSI advances. The transitions are as follows. Start (ST_IDLE to ST_LEAD) fires when the engine may run and a byte is queued; it pops that byte. Mid-bit (ST_LEAD to ST_TRAIL) fires when the half-period timer expires. Next-bit (ST_TRAIL to ST_LEAD) fires on bits 0 to 6. Finish (ST_TRAIL to ST_IDLE) fires on bit 7 and delivers the received byte. Abort, from any state to ST_IDLE, fires when the run condition drops.

Four active-low slave selects follow a control field under software control. A 7-bit status word mixes live queue flags with sticky event flags. An interrupt line is raised by any status bit whose enable is set.

Top module: `spi_reg_master`

## Requirements
- R1: After reset ss_n is 4'b1111, sclk is 0 and irq is 0. Control (offset 0x00) reads 0x00003C00, enable (0x14) reads 0, mask (0x10) reads 0, and status (0x04) reads 0x04.
- R2: ss_n always equals control bits 13:10. Software picks a slave by writing 1110, 1101, 1011 or 0111; 1111 deselects every slave.
- R3: With divider code c in control bits 5:3, each SCLK half-period lasts (1<<c) reference cycles, so one bit takes (2<<c) cycles. Code 0 divides by 2 and code 7 by 256.
- R4: MOSI sends each byte MSB first. The received byte is the eight MISO samples, MSB first. The first SCLK edge of a bit samples when CPHA (control bit 2) is 0, and the second edge samples when CPHA is 1. Each transmitted byte yields exactly one received byte.
- R5: While no byte is in flight, SCLK rests at CPOL (control bit 1).
- R6: Shifting starts only when enable bit 0 is 1, control bit 0 is 1, control bit 15 is 0 and the transmit queue is not empty. Clearing any of these conditions stops all shifting and returns SCLK to CPOL on the next cycle.
- R7: Status bits 2, 3, 4 and 5 are live. Bit 2 means the transmit queue is not full, bit 3 that it is full, bit 4 that the receive queue is not empty, and bit 5 that it is full.
- R8: Status bits 0 (receive overflow), 1 (byte complete) and 6 (transmit queue ran dry at byte completion) are sticky. Writing ones to 0x04 clears them. An event in the same cycle as the clear leaves the bit set. Ones written to the live bits have no effect.
- R9: Writing ones to 0x08 sets mask bits, and writing ones to 0x0C clears them. Offset 0x10 reads the mask. irq is the OR of the status bits whose mask bit is 1.
- R10: A write to transmit data (0x1C) while the transmit queue is full is dropped. A read of receive data (0x20) pops one byte, and when the queue is empty it returns 0 and changes nothing.
- R11: A byte that completes while the receive queue is full is discarded and sets status bit 0. The queued bytes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at 0x20) |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Active-low slave selects |

## Verification
A byte that completes in the same cycle as a software write-one-to-clear on status bit 1 puts the set and the clear on one flop. The bench forces this collision by counting cycles. With divider code 0, finish fires 17 edges after the transmit write, so the clear is issued on exactly that edge. The bench expects the bit to read back as 1, and a second clear one edge later to leave it at 0. A similar overlap, a receive push into a full queue, is forced by filling the receive queue to capacity and then queueing one more byte.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_IEN   = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_IDIS  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_IMASK = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_RUN   = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_TXD   = 6'h1C;
    localparam logic [ADDR_W-1:0] OFF_RXD   = 6'h20;

    localparam int STAT_W = 7;
    localparam logic [STAT_W-1:0] STICKY_BITS = 7'b100_0011;
    localparam logic [31:0] CTRL_RESET = 32'h0000_3C00;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TRAIL
    } eng_state_t;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // R10: a push into a full queue leaves the occupancy untouched
    a_r10_full_push_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (cnt == $past(cnt)));

    // R10: a pop from an empty queue leaves the occupancy untouched
    a_r10_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int DIV_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_ok,
    input  logic                cpol,
    input  logic                cpha,
    input  logic [DIV_BITS-1:0] div_code,
    input  logic                tx_avail,
    input  logic [7:0]          tx_byte,
    output logic                tx_take,
    input  logic                miso,
    output logic                sclk,
    output logic                mosi,
    output logic                rx_done,
    output logic [7:0]          rx_byte
);
    localparam int TW = 2 ** DIV_BITS;

    eng_state_t    state_q, state_d;
    logic [TW-1:0] timer_q, half_lim;
    logic [2:0]    bit_q;
    logic [7:0]    txs_q, rxs_q;
    logic          tick;

    assign half_lim = (TW'(1) << div_code) - TW'(1);
    assign tick     = (timer_q == half_lim);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tx_avail) state_d = ST_LEAD;
            ST_LEAD:  if (tick) state_d = ST_TRAIL;
            ST_TRAIL: if (tick) state_d = (bit_q == 3'd7) ? ST_IDLE : ST_LEAD;
            default:  state_d = ST_IDLE;
        endcase
        if (!run_ok) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            timer_q <= '0;
            bit_q   <= '0;
            txs_q   <= '0;
            rxs_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE || tick) timer_q <= '0;
            else                            timer_q <= timer_q + 1'b1;
            if (state_q == ST_IDLE)             bit_q <= '0;
            else if (state_q == ST_TRAIL && tick) bit_q <= bit_q + 1'b1;
            if (tx_take)                          txs_q <= tx_byte;
            else if (state_q == ST_TRAIL && tick) txs_q <= {txs_q[6:0], 1'b0};
            if (state_q == ST_LEAD && tick)       rxs_q <= {rxs_q[6:0], miso};
        end
    end

    always_comb begin
        tx_take = (state_q == ST_IDLE) && (state_d == ST_LEAD);
        rx_done = (state_q == ST_TRAIL) && tick && (bit_q == 3'd7);
        sclk    = cpol ^ ((state_q == ST_LEAD && cpha) || (state_q == ST_TRAIL && !cpha));
        mosi    = txs_q[7];
        rx_byte = rxs_q;
    end

    // R4: the finish transition always lands in the idle state
    a_r4_done_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> (state_q == ST_IDLE));

    // R6: a dropped run condition aborts any byte in flight
    a_r6_abort_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !run_ok |=> (state_q == ST_IDLE));

endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
    import spim_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int DIV_BITS   = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic [3:0]  ss_n
);
    logic [31:0]       ctrl_q;
    logic              en_q;
    logic [STAT_W-1:0] mask_q, stk_q, stk_set, stk_clr, status;
    logic              tx_push, tx_take, tx_empty, tx_full;
    logic              rx_pop, rx_empty, rx_full, eng_done, run_ok;
    logic [7:0]        tx_head, rx_head, rx_byte;

    assign tx_push = reg_wr && (reg_addr == OFF_TXD);
    assign rx_pop  = reg_rd && (reg_addr == OFF_RXD);
    assign run_ok  = en_q && ctrl_q[0] && !ctrl_q[15];
    assign ss_n    = ctrl_q[13:10];

    spim_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(reg_wdata[7:0]),
        .pop(tx_take), .dout(tx_head), .empty(tx_empty), .full(tx_full));

    spim_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(eng_done), .din(rx_byte),
        .pop(rx_pop), .dout(rx_head), .empty(rx_empty), .full(rx_full));

    spim_engine #(.DIV_BITS(DIV_BITS)) u_eng (
        .clk(clk), .rst_n(rst_n), .run_ok(run_ok),
        .cpol(ctrl_q[1]), .cpha(ctrl_q[2]), .div_code(ctrl_q[3 +: DIV_BITS]),
        .tx_avail(!tx_empty), .tx_byte(tx_head), .tx_take(tx_take),
        .miso(miso), .sclk(sclk), .mosi(mosi),
        .rx_done(eng_done), .rx_byte(rx_byte));

    always_comb begin
        stk_set    = '0;
        stk_set[0] = eng_done && rx_full;
        stk_set[1] = eng_done;
        stk_set[6] = eng_done && tx_empty;
        stk_clr    = (reg_wr && reg_addr == OFF_STAT) ? (reg_wdata[6:0] & STICKY_BITS) : '0;
        status     = {stk_q[6], rx_full, !rx_empty, tx_full, !tx_full, stk_q[1], stk_q[0]};
        irq        = |(status & mask_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            en_q   <= 1'b0;
            mask_q <= '0;
            stk_q  <= '0;
        end else begin
            stk_q <= (stk_q & ~stk_clr) | stk_set;
            if (reg_wr) begin
                unique case (reg_addr)
                    OFF_CTRL: ctrl_q <= reg_wdata;
                    OFF_RUN:  en_q   <= reg_wdata[0];
                    OFF_IEN:  mask_q <= mask_q | reg_wdata[6:0];
                    OFF_IDIS: mask_q <= mask_q & ~reg_wdata[6:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFF_CTRL:  reg_rdata = ctrl_q;
            OFF_STAT:  reg_rdata = {25'b0, status};
            OFF_IMASK: reg_rdata = {25'b0, mask_q};
            OFF_RUN:   reg_rdata = {31'b0, en_q};
            OFF_RXD:   reg_rdata = rx_empty ? 32'b0 : {24'b0, rx_head};
            default:   reg_rdata = 32'b0;
        endcase
    end

    // R9: ones written to the disable offset clear those mask bits
    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_IDIS) |=> ((mask_q & $past(reg_wdata[6:0])) == '0));

    // R6: with the controller off, SCLK sits at CPOL from the next cycle
    a_r6_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (sclk == ctrl_q[1]));

    // R8: a completion event beats a same-cycle clear of the byte-complete bit
    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && reg_wr && reg_addr == OFF_STAT && reg_wdata[1]) |=> stk_q[1]);

endmodule

// File: tb/tb_spi_reg_master.sv
`timescale 1ns/1ps
module tb_spi_reg_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, sclk, mosi, miso;
    logic [3:0]  ss_n;

    int checks = 0;
    int fails  = 0;

    // bench-side slave model
    logic       samp_lvl = 1'b0;
    logic [7:0] slave_byte = 8'h00;
    logic [7:0] mosi_cap = 8'h00;
    int         sedges = 0;
    int         base = 0;
    longint     last_t = 0;
    longint     period = 0;
    int         sidx;

    always #10 clk = ~clk;

    spi_reg_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n));

    assign sidx = sedges - base;
    assign miso = (sidx >= 0 && sidx < 8) ? slave_byte[3'd7 - sidx[2:0]] : 1'b0;

    always @(sclk) begin
        if (sclk === samp_lvl) begin
            mosi_cap = {mosi_cap[6:0], mosi};
            sedges   = sedges + 1;
            period   = $time - last_t;
            last_t   = $time;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] cfg(input logic cpol, input logic cpha,
                                        input logic [2:0] code, input logic [3:0] cs,
                                        input logic mstart);
        return {16'b0, mstart, 1'b0, cs, 4'b0, code, cpha, cpol, 1'b1};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        check("R1 ss_n", 32'(ss_n), 32'hF);
        check("R1 sclk", 32'(sclk), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        rd(6'h00, v); check("R1 ctrl", v, 32'h3C00);
        rd(6'h14, v); check("R1 enable", v, 32'h0);
        rd(6'h10, v); check("R1 mask", v, 32'h0);
        rd(6'h04, v); check("R1 status", v, 32'h04);
    endtask

    task automatic t_select();
        wr(6'h00, cfg(0, 0, 0, 4'b1101, 0)); check("R2 select 1", 32'(ss_n), 32'hD);
        wr(6'h00, cfg(0, 0, 0, 4'b1011, 0)); check("R2 select 2", 32'(ss_n), 32'hB);
        wr(6'h00, cfg(0, 0, 0, 4'b1111, 0)); check("R2 none", 32'(ss_n), 32'hF);
    endtask

    task automatic t_mode(input logic cpol, input logic cpha, input logic [2:0] code,
                          input logic [7:0] txb, input logic [7:0] slv);
        logic [31:0] v;
        wr(6'h00, cfg(cpol, cpha, code, 4'b1110, 0));
        wr(6'h14, 32'h1);
        samp_lvl = cpol ^ !cpha;
        slave_byte = slv;
        base = sedges;
        wr(6'h1C, 32'(txb));
        idle((2 << code) * 8 + 6);
        check("R4 mosi msb first", 32'(mosi_cap), 32'(txb));
        check("R4 one byte per byte", 32'(sedges - base), 32'd8);
        check("R3 bit period ns", 32'(period), 32'((2 << code) * 20));
        check("R5 sclk rest", 32'(sclk), 32'(cpol));
        rd(6'h20, v); check("R4 rx byte", v, 32'(slv));
    endtask

    task automatic t_gate();
        logic [31:0] v;
        wr(6'h14, 32'h0);
        wr(6'h00, cfg(0, 0, 0, 4'b1110, 0));
        samp_lvl = 1'b1; slave_byte = 8'h00; base = sedges;
        wr(6'h1C, 32'h5A);
        idle(40);
        check("R6 disabled no shift", 32'(sedges - base), 32'd0);
        check("R6 disabled sclk", 32'(sclk), 32'd0);
        rd(6'h04, v); check("R6 no rx", v & 32'h10, 32'h0);
        wr(6'h00, cfg(0, 0, 0, 4'b1110, 1));
        wr(6'h14, 32'h1);
        idle(40);
        check("R6 manual start holds", 32'(sedges - base), 32'd0);
        wr(6'h00, cfg(0, 0, 0, 4'b1110, 0));
        idle(40);
        check("R6 auto start", 32'(sedges - base), 32'd8);
        check("R6 data", 32'(mosi_cap), 32'h5A);
        rd(6'h20, v);
    endtask

    task automatic t_fifo();
        logic [31:0] v;
        wr(6'h14, 32'h0);
        wr(6'h04, 32'h7F);
        base = sedges;
        for (int i = 0; i < 129; i++) wr(6'h1C, 32'(i));
        rd(6'h04, v); check("R7 tx full flags", v & 32'h0C, 32'h08);
        wr(6'h14, 32'h1);
        idle(128 * 17 + 40);
        check("R10 full write dropped", 32'(sedges - base), 32'd1024);
        check("R10 last byte", 32'(mosi_cap), 32'h7F);
        rd(6'h04, v); check("R7 rx full flags", v & 32'h35, 32'h34);
        wr(6'h1C, 32'hEE);
        idle(40);
        rd(6'h04, v); check("R11 overflow flag", v & 32'h01, 32'h01);
        for (int i = 0; i < 127; i++) rd(6'h20, v);
        rd(6'h04, v); check("R11 kept 128", v & 32'h10, 32'h10);
        rd(6'h20, v);
        rd(6'h04, v); check("R11 empty after 128", v & 32'h10, 32'h00);
        rd(6'h20, v); check("R10 empty read", v, 32'h0);
        rd(6'h04, v); check("R10 empty read no change", v & 32'h30, 32'h00);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(6'h04, 32'h7F);
        wr(6'h0C, 32'h7F);
        check("R9 irq off", 32'(irq), 32'h0);
        wr(6'h08, 32'h14);
        rd(6'h10, v); check("R9 mask set", v, 32'h14);
        check("R9 irq on tx not full", 32'(irq), 32'h1);
        wr(6'h0C, 32'h04);
        rd(6'h10, v); check("R9 mask clear", v, 32'h10);
        check("R9 irq off again", 32'(irq), 32'h0);
        wr(6'h04, 32'h04);
        rd(6'h04, v); check("R8 live bit kept", v & 32'h04, 32'h04);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(6'h00, cfg(0, 0, 0, 4'b1110, 0));
        wr(6'h14, 32'h1);
        wr(6'h04, 32'h7F);
        wr(6'h1C, 32'h3C);
        idle(16);
        wr(6'h04, 32'h02);
        rd(6'h04, v); check("R8 set beats clear", v & 32'h02, 32'h02);
        wr(6'h04, 32'h02);
        rd(6'h04, v); check("R8 clear later", v & 32'h42, 32'h40);
        rd(6'h20, v);
    endtask

    initial begin
        #4_000_000;
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_select();
        t_mode(0, 0, 3'd0, 8'hA5, 8'h3C);
        t_mode(0, 1, 3'd2, 8'h81, 8'hC6);
        t_mode(1, 0, 3'd1, 8'h17, 8'h9E);
        t_mode(1, 1, 3'd3, 8'hF0, 8'h01);
        t_gate();
        t_fifo();
        t_irq();
        t_collide();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule